// File: doc/BRIEF.md
# Table-Driven AES Substitution Unit with Activity Masking

This block substitutes one byte per accepted transfer with the forward AES S-box value. The value comes from a constant 256-entry table that is filled at elaboration. No inversion or affine step is computed at run time. The result is captured in an output register and presented as a valid/ready stream.

In the same cycle as each lookup, a bank of eight dummy arithmetic operators switches on operands taken from the input byte and its bitwise complement. The bank has two adders, one subtractor, one divider and four multipliers. Its only purpose is to add switching activity that does not follow the processed data. The operator inputs are ANDed with the accept strobe, so they sit at zero when no lookup is taking place. The results never reach the substitution path. They are registered and brought out on a wide sink port so that synthesis keeps the operators.

Back-pressure works as follows. The unit has one output stage. `in_ready` is high when that stage is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output byte and the dummy port hold their values and no new byte is taken.

Top module: `sbox_hiding_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0, `out_byte` is 0x00, `dummy_out` is all zeros and `in_ready` is 1.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. After that edge, `out_valid` is 1 and `out_byte` equals the forward AES S-box of the byte, for every one of the 256 byte values. Examples: 0x00 maps to 0x63, 0x01 to 0x7C and 0x53 to 0xED.
- R3: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0. In such a cycle, `out_byte`, `out_valid` and `dummy_out` keep their values across the next edge, and an offered byte is not taken.
- R4: If no byte is accepted on an edge, `dummy_out` does not change across that edge.
- R5: After an accepted byte v, `dummy_out` holds 8 fields of 16 bits each. Field k occupies bits [16k+15:16k]. For field k, A is v rotated left by k and B is ~v, and the field holds:
  - k = 0 and 1: A+B, zero-extended;
  - k = 2: A-B, modulo 2^16;
  - k = 3: quotient in the upper byte and remainder in the lower byte of A/B;
  - k = 4 to 7: A*B.
- R6: When the divisor is zero (v = 0xFF), field 3 holds quotient 0xFF and remainder A, which gives 0xFFFF.
- R7: The substitution result for a byte does not depend on the byte accepted before it or on the dummy bank's state. 0x53 gives 0xED whether it follows 0x00 or 0xFF.
- R8: When `out_valid` is 1, `out_ready` is 1 and no new byte is accepted, `out_valid` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Unit can take a byte this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Substituted byte is present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_byte | output | 8 | Registered S-box result |
| dummy_out | output | 128 | Registered dummy operator results, sink only |

## Verification
The properties assume that the upstream side keeps `in_byte` meaningful only when `in_valid` is high. They also assume that `out_ready` is a plain level with no timing link to `out_valid`. Neither input is constrained beyond that.

The stimulus drives every input on the falling edge of the clock, so each input is steady at the sampling edge. It covers three traffic patterns:
- back-to-back streaming with the consumer always ready;
- isolated transfers separated by idle cycles;
- stalls where the consumer drops `out_ready` while a new byte is offered.

These patterns exercise both the accepted and the refused case of every handshake rule.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  localparam int SB_W  = 8;
  localparam int K_ADD = 0;
  localparam int K_SUB = 1;
  localparam int K_DIV = 2;
  localparam int K_MUL = 3;

  // Multiply two field elements modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
    end
    return acc;
  endfunction

  // Forward substitution value: inverse (as x^254), then the affine map.
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] sq;
    logic [7:0] r;
    inv = 8'h01;
    sq  = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) inv = gf_mul(inv, sq);
      sq = gf_mul(sq, sq);
    end
    r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
        {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return r;
  endfunction
endpackage

// File: rtl/sbh_lut.sv
module sbh_lut (
  input  logic [7:0] addr,
  output logic [7:0] data
);
  localparam int DEPTH = 1 << sbh_pkg::SB_W;

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [7:0] ENT = sbh_pkg::sbox_calc(8'(i));
    assign rom[i] = ENT;
  end

  assign data = rom[addr];
endmodule

// File: rtl/sbh_op.sv
module sbh_op #(
  parameter int KIND  = 0,
  parameter int SHIFT = 0,
  parameter int W     = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] res
);
  localparam int RW = 2 * W;

  logic [W-1:0] a_r;
  assign a_r = (a << SHIFT) | (a >> (W - SHIFT));

  if (KIND == sbh_pkg::K_ADD) begin : g_add
    logic [W:0] sum;
    assign sum = {1'b0, a_r} + {1'b0, b};
    assign res = {{(W-1){1'b0}}, sum};
  end else if (KIND == sbh_pkg::K_SUB) begin : g_sub
    assign res = RW'({{W{1'b0}}, a_r} - {{W{1'b0}}, b});
  end else if (KIND == sbh_pkg::K_DIV) begin : g_div
    logic [W-1:0] quo;
    logic [W-1:0] rem;
    assign quo = (b == '0) ? '1  : a_r / b;
    assign rem = (b == '0) ? a_r : a_r % b;
    assign res = {quo, rem};
  end else begin : g_mul
    assign res = RW'({{W{1'b0}}, a_r} * {{W{1'b0}}, b});
  end
endmodule

// File: rtl/sbh_dummy_bank.sv
module sbh_dummy_bank #(
  parameter int N_ADD = 2,
  parameter int N_SUB = 1,
  parameter int N_DIV = 1,
  parameter int N_MUL = 4,
  localparam int W     = sbh_pkg::SB_W,
  localparam int RW    = 2 * W,
  localparam int N_OPS = N_ADD + N_SUB + N_DIV + N_MUL
) (
  input  logic              en,
  input  logic [W-1:0]      byte_in,
  output logic [N_OPS*RW-1:0] res
);
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;

  // Inputs are forced to zero when no lookup is in progress.
  assign op_a = byte_in  & {W{en}};
  assign op_b = ~byte_in & {W{en}};

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    localparam int KIND = (k < N_ADD)                 ? sbh_pkg::K_ADD :
                          (k < N_ADD + N_SUB)         ? sbh_pkg::K_SUB :
                          (k < N_ADD + N_SUB + N_DIV) ? sbh_pkg::K_DIV :
                                                        sbh_pkg::K_MUL;
    sbh_op #(.KIND(KIND), .SHIFT(k % W), .W(W)) u_op (
      .a   (op_a),
      .b   (op_b),
      .res (res[k*RW +: RW])
    );
  end
endmodule

// File: rtl/sbox_hiding_unit.sv
module sbox_hiding_unit #(
  parameter int N_ADD = 2,
  parameter int N_SUB = 1,
  parameter int N_DIV = 1,
  parameter int N_MUL = 4,
  localparam int W     = sbh_pkg::SB_W,
  localparam int N_OPS = N_ADD + N_SUB + N_DIV + N_MUL,
  localparam int DW    = N_OPS * 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_byte,
  output logic [DW-1:0] dummy_out
);
  logic          fire;
  logic [W-1:0]  lut_data;
  logic [DW-1:0] bank_res;

  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  sbh_lut u_lut (
    .addr (in_byte),
    .data (lut_data)
  );

  sbh_dummy_bank #(
    .N_ADD (N_ADD),
    .N_SUB (N_SUB),
    .N_DIV (N_DIV),
    .N_MUL (N_MUL)
  ) u_bank (
    .en      (fire),
    .byte_in (in_byte),
    .res     (bank_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      dummy_out <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_byte  <= lut_data;
      dummy_out <= bank_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sbh_chk.sv
module sbh_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [7:0]   in_byte,
  input logic         out_valid,
  input logic         out_ready,
  input logic [7:0]   out_byte,
  input logic [127:0] dummy_out
);
  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_value: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_byte == sbh_pkg::sbox_calc($past(in_byte))));

  a_r3_refuse_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(dummy_out)));

  a_r4_dummy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(dummy_out));

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind sbox_hiding_unit sbh_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_byte   (in_byte),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte),
  .dummy_out (dummy_out)
);

// File: tb/sbox_hiding_unit_tb.sv
module sbox_hiding_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_byte = 8'h00;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [7:0]   out_byte;
  logic [127:0] dummy_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_t [256];
  logic [7:0] log_t [256];
  logic [7:0] ref_s [256];

  always #4 clk = ~clk;

  sbox_hiding_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .dummy_out (dummy_out)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference table: log/antilog over generator 3, then the affine map.
  task automatic build_ref();
    logic [7:0] e;
    logic [7:0] inv;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = 8'(i);
      e = e ^ (e[7] ? ((e << 1) ^ 8'h1b) : (e << 1));
    end
    for (int x = 0; x < 256; x++) begin
      if (x == 0) inv = 8'h00;
      else inv = exp_t[(255 - int'(log_t[x])) % 255];
      ref_s[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
                 {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] dummy_ref(input logic [7:0] v);
    logic [127:0] r;
    logic [7:0]   a;
    logic [7:0]   b;
    logic [15:0]  f;
    r = '0;
    b = ~v;
    for (int k = 0; k < 8; k++) begin
      a = (k == 0) ? v : ((v << k) | (v >> (8 - k)));
      case (k)
        0, 1: f = 16'(a) + 16'(b);
        2:    f = 16'(a) - 16'(b);
        3:    f = (b == 8'h00) ? {8'hFF, a} : {a / b, a % b};
        default: f = 16'(a) * 16'(b);
      endcase
      r[k*16 +: 16] = f;
    end
    return r;
  endfunction

  // One isolated transfer; results checked one cycle later.
  task automatic send_one(input logic [7:0] v);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_byte   = v;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", 128'(out_valid), 128'(0));
    chk("R1 out_byte in reset", 128'(out_byte), 128'(0));
    chk("R1 dummy_out in reset", dummy_out, '0);
    chk("R1 in_ready in reset", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 128'(out_valid), 128'(0));
  endtask

  task automatic t_known();
    send_one(8'h00); chk("R2 S(00)", 128'(out_byte), 128'(8'h63));
    chk("R2 valid", 128'(out_valid), 128'(1));
    send_one(8'h01); chk("R2 S(01)", 128'(out_byte), 128'(8'h7C));
    send_one(8'h53); chk("R2 S(53)", 128'(out_byte), 128'(8'hED));
    @(negedge clk);
    chk("R8 drained", 128'(out_valid), 128'(0));
  endtask

  task automatic t_sweep();
    out_ready = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 sweep value", 128'(out_byte), 128'(ref_s[i-1]));
        chk("R2 sweep valid", 128'(out_valid), 128'(1));
        chk("R5 sweep dummy", dummy_out, dummy_ref(8'(i-1)));
      end
      in_valid = 1'b1;
      in_byte  = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 sweep last", 128'(out_byte), 128'(ref_s[255]));
    chk("R5 sweep last dummy", dummy_out, dummy_ref(8'hFF));
  endtask

  task automatic t_divzero();
    send_one(8'hFF);
    chk("R6 divide by zero field", 128'(dummy_out[63:48]), 128'(16'hFFFF));
    chk("R6 S(FF)", 128'(out_byte), 128'(8'h16));
    send_one(8'h0F);
    chk("R5 fields for 0F", dummy_out, dummy_ref(8'h0F));
  endtask

  task automatic t_idle();
    logic [127:0] held;
    send_one(8'hA5);
    held = dummy_out;
    in_byte = 8'h3C;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_byte = ~in_byte;
      chk("R4 dummy steady while idle", dummy_out, held);
    end
  endtask

  task automatic t_stall();
    logic [127:0] held;
    send_one(8'h10);
    out_ready = 1'b0;
    held = dummy_out;
    in_valid = 1'b1;
    in_byte  = 8'h20;
    #1;
    chk("R3 in_ready low on stall", 128'(in_ready), 128'(0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 byte held", 128'(out_byte), 128'(ref_s[8'h10]));
      chk("R3 valid held", 128'(out_valid), 128'(1));
      chk("R3 dummy held", dummy_out, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 accepted after release", 128'(out_byte), 128'(ref_s[8'h20]));
    chk("R5 dummy after release", dummy_out, dummy_ref(8'h20));
  endtask

  task automatic t_independence();
    send_one(8'h00);
    send_one(8'h53); chk("R7 53 after 00", 128'(out_byte), 128'(8'hED));
    send_one(8'hFF);
    send_one(8'h53); chk("R7 53 after FF", 128'(out_byte), 128'(8'hED));
  endtask

  initial begin
    build_ref();
    t_reset();
    t_known();
    t_sweep();
    t_divzero();
    t_idle();
    t_stall();
    t_independence();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule